// File: doc/BRIEF.md
# Record and Replay Storage Controller

This block sequences the operating modes of a flight data recorder and drives a byte-wide memory. While the system is powered and a recording has been commanded, every framed byte offered by the upstream framer is written to the next memory location. On command, or on its own once memory is full, it switches to replay. Replay streams a fixed two-byte header and then every stored byte from address zero up to the highest address written. The sequence repeats without end until recording is commanded again or power goes away.

When the power-on indication drops, the controller enters a retention state. In that state the memory is deselected, every strobe is idle and the write pointer keeps its value. On the next power-up the existing recording can be replayed at once, without recording anything new.

States: RETAIN (power absent), IDLE (powered, not recording), STORE (recording), HDR_A and HDR_B (header bytes), FETCH (memory read issued), EMIT (read byte presented). Transitions: RETAIN→IDLE on power-on. Any state→RETAIN on power loss. IDLE→STORE on a store command. IDLE→HDR_A on a replay command when data exists. STORE→HDR_A on a replay command or on the write into the last address. HDR_A→HDR_B→FETCH→EMIT. EMIT→FETCH, or EMIT→HDR_A after the highest written byte. Any replay state→STORE on a store command.

Top module: `rec_replay_ctrl`

## Requirements
- R1: After reset the controller is in RETAIN with mem_cs, mem_we, mem_oe, tx_valid and full low and mem_addr equal to 0.
- R2: One cycle after pwr_on is low, mem_cs, mem_we, mem_oe and tx_valid are low whatever the commands, and the write pointer keeps its value through retention.
- R3: In IDLE, byte_valid causes no memory write (mem_we and mem_cs stay low).
- R4: In STORE, each cycle with byte_valid high drives mem_cs and mem_we high in that same cycle, with mem_wdata equal to wr_data and mem_addr equal to the number of bytes accepted since the store command.
- R5: The write into the last address (all ADDR_W bits set) raises full on the next cycle and starts replay at once; the write pointer saturates there.
- R6: A replay command while storing, with at least one byte stored, pre-empts recording: the next cycle shows the first header byte, and a byte offered in the command cycle is not written.
- R7: Each replay cycle starts with tx_valid high for two consecutive cycles carrying 0xA5 and then 0x5A.
- R8: After the header, for each address k from 0 to the highest written address, one cycle drives mem_cs and mem_oe with mem_addr = k and tx_valid low, and the next cycle presents the stored byte on tx_data with tx_valid high.
- R9: After the highest written byte, the header is sent again and replay repeats.
- R10: After power returns, a replay command replays the earlier recording with no new store.
- R11: A replay command when no byte has been stored since the last store command (or since reset) is ignored: tx_valid stays low.
- R12: A store command during replay starts a new recording at address 0 and clears full.
- R13: mem_we and mem_oe are never high together, and neither is high without mem_cs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on | input | 1 | High while system power is present |
| store_cmd | input | 1 | Start-recording command, one-cycle pulse |
| replay_cmd | input | 1 | Start-replay command, one-cycle pulse |
| byte_valid | input | 1 | Framer presents a byte to record |
| wr_data | input | DATA_W | Byte to record |
| mem_rdata | input | DATA_W | Memory read data, valid the cycle after a read strobe |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_cs | output | 1 | Memory chip select, active high |
| mem_we | output | 1 | Memory write strobe |
| mem_oe | output | 1 | Memory read strobe |
| mem_wdata | output | DATA_W | Memory write data |
| tx_valid | output | 1 | Replay byte valid |
| tx_data | output | DATA_W | Replay byte (header or stored data) |
| full | output | 1 | Memory filled by the current recording |

## Verification
Write strobes are combinational in the byte_valid cycle, so the bench checks them 1 ns after driving inputs at the falling edge, and only then lets the rising edge commit the write. A command sampled at a rising edge moves the state once, so the first header byte, the new full flag and the idle strobes of retention are all checked at the falling edge just after that rising edge. In replay each stored byte takes two cycles: the read strobe and address are checked in the FETCH cycle, and the byte, from a bench memory with one cycle of read latency, is checked in the next cycle. Expected bytes come from a bench copy of what was written.

// File: rtl/rr_pkg.sv
package rr_pkg;

    typedef enum logic [2:0] {
        ST_RETAIN,
        ST_IDLE,
        ST_STORE,
        ST_HDR_A,
        ST_HDR_B,
        ST_FETCH,
        ST_EMIT
    } rr_state_t;

endpackage

// File: rtl/rr_wr_addr.sv
module rr_wr_addr #(
    parameter int ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic [ADDR_W-1:0] top,
    output logic              has_data,
    output logic              full,
    output logic              last
);
    localparam logic [ADDR_W-1:0] MAX_ADDR = '1;

    assign last = (wr_ptr == MAX_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            top      <= '0;
            has_data <= 1'b0;
            full     <= 1'b0;
        end else if (clear) begin
            wr_ptr   <= '0;
            has_data <= 1'b0;
            full     <= 1'b0;
        end else if (advance) begin
            top      <= wr_ptr;
            has_data <= 1'b1;
            if (last) begin
                full <= 1'b1;
            end else begin
                wr_ptr <= wr_ptr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rr_rd_addr.sv
module rr_rd_addr #(
    parameter int ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [ADDR_W-1:0] top,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic              at_top
);
    assign at_top = (rd_ptr == top);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (clear) begin
            rd_ptr <= '0;
        end else if (step) begin
            rd_ptr <= rd_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/rr_fsm.sv
module rr_fsm
    import rr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pwr_on,
    input  logic      store_cmd,
    input  logic      replay_cmd,
    input  logic      byte_valid,
    input  logic      has_data,
    input  logic      wr_last,
    input  logic      rd_at_top,
    output rr_state_t state,
    output logic      wr_go,
    output logic      wr_clear,
    output logic      rd_clear,
    output logic      rd_step
);
    rr_state_t nxt;
    logic      replay_go;

    assign replay_go = replay_cmd && has_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RETAIN;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt      = state;
        wr_go    = 1'b0;
        wr_clear = 1'b0;
        rd_clear = 1'b0;
        rd_step  = 1'b0;
        unique case (state)
            ST_RETAIN: begin
                if (pwr_on) nxt = ST_IDLE;
            end
            ST_IDLE: begin
                if (replay_go) begin
                    nxt = ST_HDR_A;
                end else if (store_cmd) begin
                    nxt      = ST_STORE;
                    wr_clear = 1'b1;
                end
            end
            ST_STORE: begin
                if (replay_go) begin
                    nxt = ST_HDR_A;
                end else if (byte_valid) begin
                    wr_go = 1'b1;
                    if (wr_last) nxt = ST_HDR_A;
                end
            end
            ST_HDR_A: begin
                nxt      = ST_HDR_B;
                rd_clear = 1'b1;
            end
            ST_HDR_B: begin
                nxt = ST_FETCH;
            end
            ST_FETCH: begin
                nxt = ST_EMIT;
            end
            ST_EMIT: begin
                if (rd_at_top) begin
                    nxt = ST_HDR_A;
                end else begin
                    nxt     = ST_FETCH;
                    rd_step = 1'b1;
                end
            end
            default: nxt = ST_RETAIN;
        endcase

        if (store_cmd && (state == ST_HDR_A || state == ST_HDR_B ||
                          state == ST_FETCH || state == ST_EMIT)) begin
            nxt      = ST_STORE;
            wr_clear = 1'b1;
            rd_clear = 1'b0;
            rd_step  = 1'b0;
        end

        if (!pwr_on) begin
            nxt      = ST_RETAIN;
            wr_go    = 1'b0;
            wr_clear = 1'b0;
            rd_clear = 1'b0;
            rd_step  = 1'b0;
        end
    end
endmodule

// File: rtl/rec_replay_ctrl.sv
module rec_replay_ctrl
    import rr_pkg::*;
#(
    parameter int                ADDR_W     = 21,
    parameter int                DATA_W     = 8,
    parameter logic [DATA_W-1:0] HDR_FIRST  = 8'hA5,
    parameter logic [DATA_W-1:0] HDR_SECOND = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_on,
    input  logic              store_cmd,
    input  logic              replay_cmd,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs,
    output logic              mem_we,
    output logic              mem_oe,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              full
);
    rr_state_t         state;
    logic              wr_go, wr_clear, rd_clear, rd_step;
    logic              has_data, wr_last, rd_at_top;
    logic [ADDR_W-1:0] wr_ptr, top, rd_ptr;

    rr_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_on     (pwr_on),
        .store_cmd  (store_cmd),
        .replay_cmd (replay_cmd),
        .byte_valid (byte_valid),
        .has_data   (has_data),
        .wr_last    (wr_last),
        .rd_at_top  (rd_at_top),
        .state      (state),
        .wr_go      (wr_go),
        .wr_clear   (wr_clear),
        .rd_clear   (rd_clear),
        .rd_step    (rd_step)
    );

    rr_wr_addr #(.ADDR_W(ADDR_W)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (wr_clear),
        .advance  (wr_go),
        .wr_ptr   (wr_ptr),
        .top      (top),
        .has_data (has_data),
        .full     (full),
        .last     (wr_last)
    );

    rr_rd_addr #(.ADDR_W(ADDR_W)) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (rd_clear),
        .step   (rd_step),
        .top    (top),
        .rd_ptr (rd_ptr),
        .at_top (rd_at_top)
    );

    always_comb begin
        mem_we    = wr_go;
        mem_oe    = (state == ST_FETCH);
        mem_cs    = mem_we || mem_oe;
        mem_addr  = (state == ST_FETCH) ? rd_ptr : wr_ptr;
        mem_wdata = wr_data;
        tx_valid  = 1'b0;
        tx_data   = '0;
        unique case (state)
            ST_HDR_A: begin
                tx_valid = 1'b1;
                tx_data  = HDR_FIRST;
            end
            ST_HDR_B: begin
                tx_valid = 1'b1;
                tx_data  = HDR_SECOND;
            end
            ST_EMIT: begin
                tx_valid = 1'b1;
                tx_data  = mem_rdata;
            end
            default: begin
                tx_valid = 1'b0;
                tx_data  = '0;
            end
        endcase
    end
endmodule

// File: rtl/rec_replay_chk.sv
module rec_replay_chk
    import rr_pkg::*;
#(
    parameter int                ADDR_W     = 21,
    parameter int                DATA_W     = 8,
    parameter logic [DATA_W-1:0] HDR_FIRST  = 8'hA5,
    parameter logic [DATA_W-1:0] HDR_SECOND = 8'h5A
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_on,
    input logic              store_cmd,
    input logic              replay_cmd,
    input rr_state_t         state,
    input logic              has_data,
    input logic [ADDR_W-1:0] wr_ptr,
    input logic              mem_cs,
    input logic              mem_we,
    input logic              mem_oe,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              tx_valid,
    input logic [DATA_W-1:0] tx_data,
    input logic              full
);
    localparam logic [ADDR_W-1:0] MAX_ADDR = '1;

    assert_quiet_retention_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |=> (!mem_cs && !mem_we && !mem_oe && !tx_valid));

    assert_ptr_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RETAIN) |=> $stable(wr_ptr));

    assert_idle_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !mem_we);

    assert_full_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_addr == MAX_ADDR) |=> (full && tx_valid && tx_data == HDR_FIRST));

    assert_full_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !store_cmd) |=> full);

    assert_preempt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STORE && pwr_on && replay_cmd && has_data)
        |=> (tx_valid && tx_data == HDR_FIRST));

    assert_header_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HDR_A && pwr_on && !store_cmd)
        |=> (tx_valid && tx_data == HDR_SECOND));

    assert_strobe_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_oe));

    assert_strobe_cs_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_oe) |-> mem_cs);
endmodule

bind rec_replay_ctrl rec_replay_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .HDR_FIRST  (HDR_FIRST),
    .HDR_SECOND (HDR_SECOND)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_on     (pwr_on),
    .store_cmd  (store_cmd),
    .replay_cmd (replay_cmd),
    .state      (state),
    .has_data   (has_data),
    .wr_ptr     (wr_ptr),
    .mem_cs     (mem_cs),
    .mem_we     (mem_we),
    .mem_oe     (mem_oe),
    .mem_addr   (mem_addr),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .full       (full)
);

// File: tb/sim_rec_replay_ctrl.sv
module sim_rec_replay_ctrl;
    localparam int AW    = 5;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n, pwr_on, store_cmd, replay_cmd, byte_valid;
    logic [DW-1:0] wr_data, mem_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_cs, mem_we, mem_oe, tx_valid, full;
    logic [DW-1:0] mem_wdata, tx_data;

    logic [DW-1:0] mem     [DEPTH];
    logic [DW-1:0] exp_mem [DEPTH];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    rec_replay_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .store_cmd(store_cmd),
        .replay_cmd(replay_cmd), .byte_valid(byte_valid), .wr_data(wr_data),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_cs(mem_cs),
        .mem_we(mem_we), .mem_oe(mem_oe), .mem_wdata(mem_wdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .full(full)
    );

    always @(posedge clk) begin
        if (mem_cs && mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_cs && mem_oe) mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic put_byte(input int idx, input logic [DW-1:0] d, input string req);
        byte_valid = 1'b1;
        wr_data    = d;
        #1;
        chk({req, " we"},    mem_we, 1);
        chk({req, " cs"},    mem_cs, 1);
        chk({req, " addr"},  mem_addr, idx);
        chk({req, " wdata"}, mem_wdata, d);
        exp_mem[idx] = d;
        step();
        byte_valid = 1'b0;
    endtask

    task automatic check_header(input string req);
        #1;
        chk({req, " hdr1 valid"}, tx_valid, 1);
        chk({req, " hdr1 byte"},  tx_data, 8'hA5);
        step();
        #1;
        chk({req, " hdr2 valid"}, tx_valid, 1);
        chk({req, " hdr2 byte"},  tx_data, 8'h5A);
        step();
    endtask

    task automatic check_replay(input int n, input string req);
        check_header({req, " R7"});
        for (int i = 0; i < n; i++) begin
            #1;
            chk({req, " R8 oe"},    mem_oe, 1);
            chk({req, " R8 cs"},    mem_cs, 1);
            chk({req, " R8 addr"},  mem_addr, i);
            chk({req, " R13 we"},   mem_we, 0);
            chk({req, " R8 idle"},  tx_valid, 0);
            step();
            #1;
            chk({req, " R8 valid"}, tx_valid, 1);
            chk({req, " R8 data"},  tx_data, exp_mem[i]);
            step();
        end
        check_header({req, " R9 repeat"});
    endtask

    task automatic t_reset;
        rst_n = 1'b0; pwr_on = 1'b0; store_cmd = 1'b0; replay_cmd = 1'b0;
        byte_valid = 1'b0; wr_data = '0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        #1;
        chk("R1 cs", mem_cs, 0);
        chk("R1 we", mem_we, 0);
        chk("R1 oe", mem_oe, 0);
        chk("R1 tx_valid", tx_valid, 0);
        chk("R1 full", full, 0);
        chk("R1 addr", mem_addr, 0);
    endtask

    task automatic t_idle_ignore;
        pwr_on = 1'b1;
        step();
        byte_valid = 1'b1;
        wr_data    = 8'h33;
        #1;
        chk("R3 we in idle", mem_we, 0);
        chk("R3 cs in idle", mem_cs, 0);
        step();
        byte_valid = 1'b0;
        replay_cmd = 1'b1;
        step();
        replay_cmd = 1'b0;
        #1;
        chk("R11 no replay without data", tx_valid, 0);
        chk("R11 no read without data", mem_oe, 0);
    endtask

    task automatic t_store_preempt;
        store_cmd = 1'b1;
        step();
        store_cmd = 1'b0;
        for (int i = 0; i < 6; i++) begin
            put_byte(i, 8'h10 + 8'(i * 9), "R4");
            if (i % 2 == 1) step();
        end
        replay_cmd = 1'b1;
        byte_valid = 1'b1;
        wr_data    = 8'hEE;
        #1;
        chk("R6 byte not written", mem_we, 0);
        step();
        replay_cmd = 1'b0;
        byte_valid = 1'b0;
        check_replay(6, "R6");
    endtask

    task automatic t_restart;
        store_cmd = 1'b1;
        step();
        store_cmd = 1'b0;
        #1;
        chk("R12 full cleared", full, 0);
        chk("R12 no tx", tx_valid, 0);
        put_byte(0, 8'hC1, "R12");
        put_byte(1, 8'hA5, "R12");
        put_byte(2, 8'h7E, "R12");
    endtask

    task automatic t_power;
        pwr_on = 1'b0;
        step();
        #1;
        chk("R2 cs", mem_cs, 0);
        chk("R2 tx_valid", tx_valid, 0);
        byte_valid = 1'b1; store_cmd = 1'b1; replay_cmd = 1'b1;
        #1;
        chk("R2 we under commands", mem_we, 0);
        step();
        #1;
        chk("R2 cs under commands", mem_cs, 0);
        chk("R2 oe under commands", mem_oe, 0);
        chk("R2 tx under commands", tx_valid, 0);
        byte_valid = 1'b0; store_cmd = 1'b0; replay_cmd = 1'b0;
        step();
        pwr_on = 1'b1;
        step();
        replay_cmd = 1'b1;
        step();
        replay_cmd = 1'b0;
        check_replay(3, "R10");
    endtask

    task automatic t_full;
        store_cmd = 1'b1;
        step();
        store_cmd = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            put_byte(i, 8'(i * 7 + 3), "R4 fill");
        end
        #1;
        chk("R5 full raised", full, 1);
        check_replay(DEPTH, "R5");
        #1;
        chk("R5 full held", full, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_idle_ignore();
        t_store_preempt();
        t_restart();
        t_power();
        t_full();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule